// File: doc/BRIEF.md
# USB Transmit Handshake and Serializer

This block is the transmit half of a USB 2.0 transceiver macrocell. The serial interface engine hands it packet bytes on an 8-bit bus through a valid/ready handshake. The block turns each packet into a single-ended line state stream at one bit per clock. It sends a synchronisation pattern first. Then come the supplied bytes, least significant bit first, with bit stuffing and NRZI coding. An end-of-packet sequence closes the packet. The engine supplies the CRC bytes as ordinary data, so the block computes no checksum.

The engine starts a packet by raising `txValid` with the PID on `txData`, and it holds each byte until the block takes it. A byte is taken on any rising edge where `txReady` and `txValid` are both high. The engine ends the packet by dropping `txValid` after its last byte is taken. The block then finishes any pending stuff bit, sends the end-of-packet sequence and returns to idle. It can start a new packet in the very next cycle. Inter-packet spacing is the engine's job.

Top module: `usb_tx_serial`

## Requirements
- R1: While `rst` is high at a rising edge, the block is held in a reset state: `txReady` is low and `lineState` is J (2'b01). In the first cycle after `rst` falls, `txValid` is ignored and `txReady` stays low. Idle wait begins one cycle later.
- R2: When the block is idle and samples `txValid` high at a rising edge, it sends the 8-bit pattern 0,0,0,0,0,0,0,1 in the following 8 cycles. Starting from J, `lineState` shows K,J,K,J,K,J,K,K, each value one cycle after the slot that produced it.
- R3: `txReady` is high only in the cycle just before the first bit of the next byte would be sent, and only while `txValid` is high. A byte is consumed on a rising edge where both are high. The first byte consumed is the PID, at the end of the last pattern slot.
- R4: Each consumed byte is sent least significant bit first. Under NRZI, a 0 bit toggles the line between J (2'b01) and K (2'b10), and a 1 bit holds it.
- R5: After six consecutive 1 bits, a 0 bit is inserted. The run count spans byte boundaries and starts at zero on the PID; the synchronisation pattern does not count toward it.
- R6: If a stuff bit follows the last bit of a byte, `txReady` is raised in the stuff bit's cycle rather than in the last data bit's cycle.
- R7: If `txValid` is low at a byte boundary, the packet ends. `lineState` shows SE0 (2'b00) for two bit times and then J for one bit time, and then the block is idle. `txReady` stays low from the drop of `txValid` until the next packet's first boundary.
- R8: A new packet may start in the cycle right after the end-of-packet J bit, with no extra idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock; every signal is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| txData | input | 8 | Byte from the engine; the PID first, held until consumed |
| txValid | input | 1 | Engine has a byte to send; dropping it ends the packet |
| txReady | output | 1 | Block takes `txData` on this edge if `txValid` is high |
| lineState | output | 2 | Line state: 2'b01 J, 2'b10 K, 2'b00 SE0 |

## Verification
One PID is 0x1F, whose five leading ones follow the final 1 of the sync pattern. A design that counted the pattern toward the run would insert a spurious zero and shift every later line state. Other packets place a six-ones run entirely at the end of a byte, split a run across two bytes, and end the last byte with a run. A design that raised `txReady` on the last data bit would pull the next byte one slot early. A design that cleared the run count per byte would miss the split run. A design that jumped to the end-of-packet sequence would drop the final stuff bit. A back-to-back packet and a reset in the middle of a packet, released with `txValid` already high, check that no cycle is lost or wrongly started at either boundary.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;

  typedef enum logic [1:0] {
    LINE_SE0 = 2'b00,
    LINE_J   = 2'b01,
    LINE_K   = 2'b10
  } lineT;

  // What the line register does at the coming edge
  typedef enum logic [1:0] {
    EM_J,     // force idle J
    EM_SE0,   // force single-ended zero
    EM_BIT,   // NRZI of the current shift bit
    EM_ZERO   // NRZI of an inserted zero
  } emitT;

  typedef struct packed {
    logic loadSync;
    logic loadByte;
    logic shift;
    emitT emit;
  } txStrobeT;

endpackage

// File: rtl/usb_tx_ctrl.sv
module usb_tx_ctrl
  import usb_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STUFF_RUN = 6,
  parameter int EOP_SE0   = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     txValid,
  input  logic     curBit,
  output logic     txReady,
  output txStrobeT strobe
);

  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int ONES_W = $clog2(STUFF_RUN + 1);
  localparam int EOP_W  = $clog2(EOP_SE0 + 1);

  typedef enum logic [2:0] {
    ST_RESET,
    ST_IDLE,
    ST_SYNC,
    ST_DATA,
    ST_EOP
  } stateT;

  stateT              state;
  logic [CNT_W-1:0]   bitCnt;   // DATA_W means byte done, stuff bit pending
  logic [ONES_W-1:0]  ones;
  logic [EOP_W-1:0]   eopCnt;

  logic               stuffNow;
  logic               lastBit;
  logic               boundary;
  logic [ONES_W-1:0]  onesNext;

  always_comb begin
    stuffNow = (state == ST_DATA) && (ones == ONES_W'(STUFF_RUN));
    if (stuffNow || !curBit) onesNext = '0;
    else                     onesNext = ones + 1'b1;
    lastBit = (bitCnt == CNT_W'(DATA_W - 1));
    unique case (state)
      ST_SYNC: boundary = lastBit;
      ST_DATA: boundary = stuffNow ? (bitCnt == CNT_W'(DATA_W))
                                   : (lastBit && (onesNext != ONES_W'(STUFF_RUN)));
      default: boundary = 1'b0;
    endcase
    txReady = boundary && txValid;
  end

  always_comb begin
    strobe = '{loadSync: 1'b0, loadByte: 1'b0, shift: 1'b0, emit: EM_J};
    unique case (state)
      ST_IDLE: strobe.loadSync = txValid;
      ST_SYNC: begin
        strobe.emit     = EM_BIT;
        strobe.shift    = 1'b1;
        strobe.loadByte = txReady;
      end
      ST_DATA: begin
        strobe.emit     = stuffNow ? EM_ZERO : EM_BIT;
        strobe.shift    = !stuffNow;
        strobe.loadByte = txReady;
      end
      ST_EOP:  strobe.emit = (eopCnt < EOP_W'(EOP_SE0)) ? EM_SE0 : EM_J;
      default: strobe.emit = EM_J;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_RESET;
      bitCnt <= '0;
      ones   <= '0;
      eopCnt <= '0;
    end else begin
      unique case (state)
        ST_RESET: state <= ST_IDLE;
        ST_IDLE: if (txValid) begin
          state  <= ST_SYNC;
          bitCnt <= '0;
          ones   <= '0;
        end
        ST_SYNC: begin
          if (boundary) begin
            bitCnt <= '0;
            if (txValid) state <= ST_DATA;
            else begin
              state  <= ST_EOP;
              eopCnt <= '0;
            end
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_DATA: begin
          ones <= onesNext;
          if (boundary) begin
            bitCnt <= '0;
            if (!txValid) begin
              state  <= ST_EOP;
              eopCnt <= '0;
            end
          end else if (!stuffNow) begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_EOP: begin
          if (eopCnt == EOP_W'(EOP_SE0)) state <= ST_IDLE;
          else                           eopCnt <= eopCnt + 1'b1;
        end
        default: state <= ST_RESET;
      endcase
    end
  end

  // R1: the cycle after release is still the reset state
  a_r1_ready_low_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !txReady);

  // R2: a valid seen while idle starts the pattern at its first slot
  a_r2_sync_follows_valid: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && txValid) |=> (state == ST_SYNC && bitCnt == '0));

  // R3: consumed bytes are at least one byte time apart
  a_r3_no_back_to_back_take: assert property (@(posedge clk) disable iff (rst)
    (txReady && txValid) |=> !txReady);

  // R7: a boundary without a valid byte leads to the end sequence
  a_r7_end_goes_to_eop: assert property (@(posedge clk) disable iff (rst)
    (boundary && !txValid) |=> (state == ST_EOP && !txReady));

endmodule

// File: rtl/usb_tx_dpath.sv
module usb_tx_dpath
  import usb_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] txData,
  input  txStrobeT          strobe,
  output logic              curBit,
  output lineT              lineState
);

  localparam logic [DATA_W-1:0] SYNC_WORD = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] shReg;

  function automatic lineT flipLine(input lineT cur);
    return (cur == LINE_K) ? LINE_J : LINE_K;
  endfunction

  assign curBit = shReg[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      shReg     <= '0;
      lineState <= LINE_J;
    end else begin
      if (strobe.loadSync)      shReg <= SYNC_WORD;
      else if (strobe.loadByte) shReg <= txData;
      else if (strobe.shift)    shReg <= shReg >> 1;

      unique case (strobe.emit)
        EM_J:    lineState <= LINE_J;
        EM_SE0:  lineState <= LINE_SE0;
        EM_BIT:  if (!curBit) lineState <= flipLine(lineState);
        EM_ZERO: lineState <= flipLine(lineState);
        default: lineState <= LINE_J;
      endcase
    end
  end

  // R1: line is idle J right after reset
  a_r1_line_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lineState == LINE_J));

  // R4: a 1 data bit leaves the line unchanged
  a_r4_one_holds_line: assert property (@(posedge clk) disable iff (rst)
    (strobe.emit == EM_BIT && curBit) |=> $stable(lineState));

  // R5: an inserted zero always produces a J/K transition
  a_r5_stuff_flips_line: assert property (@(posedge clk) disable iff (rst)
    (strobe.emit == EM_ZERO) |=>
      (lineState != $past(lineState) && lineState != LINE_SE0));

endmodule

// File: rtl/usb_tx_serial.sv
module usb_tx_serial
  import usb_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STUFF_RUN = 6,
  parameter int EOP_SE0   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic [1:0]        lineState
);

  txStrobeT strobe;
  logic     curBit;
  lineT     lineQ;

  usb_tx_ctrl #(
    .DATA_W   (DATA_W),
    .STUFF_RUN(STUFF_RUN),
    .EOP_SE0  (EOP_SE0)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .txValid(txValid),
    .curBit (curBit),
    .txReady(txReady),
    .strobe (strobe)
  );

  usb_tx_dpath #(
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .txData   (txData),
    .strobe   (strobe),
    .curBit   (curBit),
    .lineState(lineQ)
  );

  assign lineState = lineQ;

endmodule

// File: tb/usb_tx_serial_bench.sv
`timescale 1ns/1ps
module usb_tx_serial_bench;

  localparam logic [1:0] L_SE0 = 2'b00;
  localparam logic [1:0] L_J   = 2'b01;
  localparam logic [1:0] L_K   = 2'b10;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] txData;
  logic       txValid;
  logic       txReady;
  logic [1:0] lineState;

  int vectors = 0;
  int miscompares = 0;

  // Slot kinds: 0 / 1 data bit, 2 SE0, 3 forced J
  int    slotKind[$];
  bit    slotRdy[$];
  string slotReq[$];

  always #2 clk = ~clk;

  usb_tx_serial u_usb_tx_serial (
    .clk      (clk),
    .rst      (rst),
    .txData   (txData),
    .txValid  (txValid),
    .txReady  (txReady),
    .lineState(lineState)
  );

  task automatic checkVal(input string req, input string what,
                          input logic [1:0] act, input logic [1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic buildSlots(input logic [7:0] pkt[$], input string idleTag);
    int ones;
    slotKind.delete(); slotRdy.delete(); slotReq.delete();
    slotKind.push_back(3); slotRdy.push_back(1'b0); slotReq.push_back(idleTag);
    for (int i = 0; i < 8; i++) begin
      slotKind.push_back(i == 7 ? 1 : 0);
      slotRdy.push_back(i == 7);
      slotReq.push_back("R2");
    end
    ones = 0;
    for (int b = 0; b < pkt.size(); b++) begin
      for (int i = 0; i < 8; i++) begin
        slotKind.push_back(int'(pkt[b][i]));
        slotRdy.push_back(1'b0);
        slotReq.push_back("R4");
        ones = pkt[b][i] ? ones + 1 : 0;
        if (ones == 6) begin
          slotKind.push_back(0);
          slotRdy.push_back(1'b0);
          slotReq.push_back("R5");
          ones = 0;
        end
      end
      if (b != pkt.size() - 1) begin
        slotRdy[slotRdy.size() - 1] = 1'b1;
        slotReq[slotReq.size() - 1] = (slotReq[slotReq.size() - 1] == "R5") ? "R6" : "R3";
      end
    end
    for (int i = 0; i < 3; i++) begin
      slotKind.push_back(i < 2 ? 2 : 3);
      slotRdy.push_back(1'b0);
      slotReq.push_back("R7");
    end
  endtask

  // Drives one packet and compares every cycle against the slot model
  task automatic runPacket(input logic [7:0] pkt[$], input string idleTag, input int abortAt);
    int         idx;
    bit         lastFire;
    logic [1:0] expLine;
    buildSlots(pkt, idleTag);
    idx = 0;
    lastFire = 1'b0;
    expLine = L_J;
    for (int c = 0; c < slotKind.size(); c++) begin
      @(negedge clk);
      if (abortAt >= 0 && c == abortAt) return;
      if (lastFire) idx++;
      txValid = (idx < pkt.size());
      txData  = txValid ? pkt[idx] : 8'h00;
      #1;
      checkVal(slotReq[c], "txReady", {1'b0, txReady}, {1'b0, slotRdy[c]});
      checkVal(slotReq[c], "lineState", lineState, expLine);
      lastFire = txReady && txValid;
      case (slotKind[c])
        0:       expLine = (expLine == L_K) ? L_J : L_K;
        1:       expLine = expLine;
        2:       expLine = L_SE0;
        default: expLine = L_J;
      endcase
    end
  endtask

  task automatic idleCheck(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      txValid = 1'b0;
      #1;
      checkVal("R7", "txReady idle", {1'b0, txReady}, 2'b00);
      checkVal("R7", "lineState idle", lineState, L_J);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0] p[$];
    rst = 1'b1;
    txValid = 1'b0;
    txData = 8'h00;
    repeat (3) @(negedge clk);
    txValid = 1'b1;
    txData = 8'hC3;
    #1;
    checkVal("R1", "txReady in reset", {1'b0, txReady}, 2'b00);
    checkVal("R1", "lineState in reset", lineState, L_J);
    @(negedge clk);
    txValid = 1'b0;
    rst = 1'b0;
    #1;
    checkVal("R1", "txReady after release", {1'b0, txReady}, 2'b00);
    checkVal("R1", "lineState after release", lineState, L_J);

    // basic packet
    p = '{8'hC3, 8'h12, 8'hA5};
    runPacket(p, "R2", -1);
    // back-to-back; PID 0x1F must not be stuffed after the pattern, 0xFC stuffs at byte end
    p = '{8'h1F, 8'hFC, 8'h00};
    runPacket(p, "R8", -1);
    // mid-byte run, run split over bytes, stuff before end sequence
    p = '{8'h3F, 8'hE0, 8'h07, 8'hFF, 8'hFC};
    runPacket(p, "R8", -1);
    idleCheck(3);
    // PID-only packet
    p = '{8'hA5};
    runPacket(p, "R2", -1);
    // packet cut by reset
    p = '{8'hC3, 8'hFF, 8'h11, 8'h22};
    runPacket(p, "R2", 20);
    rst = 1'b1;
    repeat (2) begin
      @(negedge clk);
      #1;
      checkVal("R1", "txReady mid-packet reset", {1'b0, txReady}, 2'b00);
      checkVal("R1", "lineState mid-packet reset", lineState, L_J);
    end
    @(negedge clk);
    rst = 1'b0;
    txValid = 1'b1;
    txData = 8'h69;
    #1;
    checkVal("R1", "txReady valid ignored after release", {1'b0, txReady}, 2'b00);
    checkVal("R1", "lineState after release", lineState, L_J);
    p = '{8'h69, 8'h5A};
    runPacket(p, "R1", -1);
    idleCheck(4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule